// File: doc/BRIEF.md
# Configuration Signal Router

This block steers the configuration signals of a programmable target device among three parties: a local PROM, an upstream chain connector and a downstream chain connector. An eight-position mode code, read from a rotary selector, picks the data source, the clock source, the mode pins the target sees, the chip-select handling, the data-bus direction and what is passed on to the next board. All tri-state pins are modelled as a value plus an explicit output enable. A value whose enable is low reads 0.

The selector and the two-bit chip-select ID are asynchronous. They pass through a synchronizer and are applied only while a program request is asserted or the target's done flag is low. Once a device has configured, turning the switch cannot disturb it. The INIT and DONE flags returned upstream combine the local target with the rest of the chain. An eight-bit LED bank shows the selected mode before configuration, goes dark while configuration runs, and mirrors the target's data bus once done is reached.

Top module: `cfg_route_ctrl`

## Requirements
- R1: `mode_sel`, `id_sel`, `prog_req`, `tgt_done`, `tgt_init` and `dll_locked` pass through two flip-flops. The synchronized mode and ID become active on the next edge only when synchronized `prog_req` is 1 or synchronized `tgt_done` is 0. Otherwise the active mode and ID hold.
- R2: During and after reset, until a new mode is applied, the active mode is 7. All enables are low and `led_oe` is 0.
- R3: `tgt_mode` is driven with `tgt_mode_oe`=1 as follows: mode 0 gives 3'b000, mode 2 gives 3'b011, mode 5 gives 3'b101, and mode 6 gives 3'b110. Modes 1, 3 and 4 copy `up_mode`.
- R4: In mode 2, `tgt_cs`=0 and `tgt_rdwr`=1. In modes 0, 1 and 3 to 6, `tgt_cs`=`up_cs[id]` (active low) and `tgt_rdwr`=`up_rdwr`. Both are enabled in modes 0 to 6.
- R5: The target data bus is driven from `prom_data` in modes 0 and 2. It is driven from `up_data_in` in modes 1, 3 and 4, and in mode 6 when `up_rdwr`=1. It is not driven in modes 5 and 7.
- R6: `tgt_cclk` is driven from `up_cclk` in modes 4 and 6 only.
- R7: In modes 0 and 1, `dn_cclk`=`tgt_cclk_in` with `dn_cclk_en`=1, `dn_data_en`=8'h01, and `dn_data` bit 0 carries the target's data source.
- R8: In modes 2 and 3, `dn_cclk` is forwarded as in R7 and `dn_data_en`=8'hFF with all eight source bits. In modes 4 to 7 nothing is forwarded downstream.
- R9: In mode 6 with `up_rdwr`=0 (readback), the target bus is not driven. `up_data_out`=`tgt_data_in` with `up_data_oe`=1 exactly when `up_cs[id]`=0.
- R10: `up_data_oe` is never 1 while `up_cs[id]`=1 or while `tgt_data_oe`=1.
- R11: `up_init`=`tgt_init` AND `dn_init`, and `up_done`=`tgt_done` AND `dn_done`, in every mode.
- R12: In mode 7, every enable toward the target and every downstream enable is 0.
- R13: Setup display: the LED register loads with `led_oe`=1. Bit k (k=0..6) is 1 exactly when the active mode is k, and bit 7 equals synchronized `dll_locked`. This applies when neither R14 case holds.
- R14: The LED register loads `tgt_data_in` with `led_oe`=1 when synchronized done=1 and prog=0. It loads 0 with `led_oe`=0 when synchronized init=1, done=0 and prog=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Rotary mode code, asynchronous |
| id_sel | input | 2 | Chip-select ID, asynchronous |
| prog_req | input | 1 | Program request |
| dll_locked | input | 1 | Clock lock status for LED 7 |
| tgt_init | input | 1 | Target INIT flag |
| tgt_done | input | 1 | Target DONE flag |
| tgt_cclk_in | input | 1 | Configuration clock produced by a master-mode target |
| tgt_data_in | input | 8 | Target data bus as read back |
| prom_data | input | 8 | Local PROM data |
| up_cclk | input | 1 | Upstream configuration clock |
| up_data_in | input | 8 | Upstream data bus |
| up_cs | input | 4 | Upstream chip selects, active low |
| up_rdwr | input | 1 | Upstream direction, 0 = readback |
| up_mode | input | 3 | Upstream mode pins |
| dn_init | input | 1 | Downstream INIT |
| dn_done | input | 1 | Downstream DONE |
| tgt_mode | output | 3 | Target mode pins |
| tgt_mode_oe | output | 1 | Mode pin enable |
| tgt_cs | output | 1 | Target chip select |
| tgt_cs_oe | output | 1 | Chip select enable |
| tgt_rdwr | output | 1 | Target direction pin |
| tgt_rdwr_oe | output | 1 | Direction pin enable |
| tgt_cclk | output | 1 | Clock toward target |
| tgt_cclk_oe | output | 1 | Clock enable |
| tgt_data_out | output | 8 | Data toward target |
| tgt_data_oe | output | 1 | Target data enable |
| up_data_out | output | 8 | Readback data toward upstream |
| up_data_oe | output | 1 | Upstream data enable |
| up_init | output | 1 | Chain INIT |
| up_done | output | 1 | Chain DONE |
| dn_cclk | output | 1 | Forwarded clock |
| dn_cclk_en | output | 1 | Forwarded clock enable |
| dn_data | output | 8 | Forwarded data |
| dn_data_en | output | 8 | Per-bit forward enables |
| led | output | 8 | LED drive |
| led_oe | output | 1 | LED drive enable |

## Verification
A corrupted active mode or ID shows up at once on the combinational routing outputs. The mode pins, enables, chip-select pick and forward mask all go wrong in the same cycle, and the LED one-hot goes wrong one cycle later. A wrong hold/apply decision shows as a routing change that occurs when it should not, or that fails to occur three edges after a selector change. The reference model therefore tracks the synchronizer pipeline cycle by cycle. It compares every output each cycle while the data, chip-select and chain inputs change randomly, so a fault in the readback chip-select match is exposed as soon as an unselected readback occurs.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_SER_PROM  = 3'd0,
        M_SER_UP    = 3'd1,
        M_SMAP_PROM = 3'd2,
        M_SMAP_UP   = 3'd3,
        M_SLV_SER   = 3'd4,
        M_JTAG      = 3'd5,
        M_SMAP      = 3'd6,
        M_EXT       = 3'd7
    } cfg_mode_e;

    localparam logic [MODE_W-1:0] PINS_SER_MASTER  = 3'b000;
    localparam logic [MODE_W-1:0] PINS_SMAP_MASTER = 3'b011;
    localparam logic [MODE_W-1:0] PINS_JTAG        = 3'b101;
    localparam logic [MODE_W-1:0] PINS_SMAP_SLAVE  = 3'b110;
endpackage

// File: rtl/cfgr_sync.sv
module cfgr_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/cfgr_mode_ctrl.sv
module cfgr_mode_ctrl
    import cfgr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_s,
    input  logic [ID_W-1:0]   id_s,
    input  logic              prog_s,
    input  logic              done_s,
    input  logic              init_s,
    input  logic              dll_s,
    input  logic [DATA_W-1:0] tgt_data_in,
    output logic [MODE_W-1:0] act_mode,
    output logic [ID_W-1:0]   act_id,
    output logic [DATA_W-1:0] led,
    output logic              led_oe
);
    localparam int HOT_W = DATA_W - 1;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] led;
        logic              led_oe;
    } state_t;

    state_t state_d, state_q;
    logic [HOT_W-1:0] mode_hot;
    logic             apply_sel;

    always_comb begin
        for (int i = 0; i < HOT_W; i++) begin
            mode_hot[i] = (state_q.mode == MODE_W'(i));
        end
    end

    always_comb begin
        state_d   = state_q;
        apply_sel = prog_s || !done_s;
        if (apply_sel) begin
            state_d.mode = mode_s;
            state_d.id   = id_s;
        end
        if (done_s && !prog_s) begin
            state_d.led    = tgt_data_in;
            state_d.led_oe = 1'b1;
        end else if (init_s && !prog_s) begin
            state_d.led    = '0;
            state_d.led_oe = 1'b0;
        end else begin
            state_d.led    = {dll_s, mode_hot};
            state_d.led_oe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{mode: M_EXT, id: '0, led: '0, led_oe: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign act_mode = state_q.mode;
    assign act_id   = state_q.id;
    assign led      = state_q.led;
    assign led_oe   = state_q.led_oe;

    assert_hold_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_s && !prog_s) |=> $stable(state_q.mode) && $stable(state_q.id));

    assert_apply_selector_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_s || !done_s) |=> (state_q.mode == $past(mode_s)));

    assert_led_dark_cfg_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (init_s && !done_s && !prog_s) |=> !led_oe);

    assert_led_hot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_s && !done_s) |=> $onehot0(led[HOT_W-1:0]) && led_oe);
endmodule

// File: rtl/cfgr_route.sv
module cfgr_route
    import cfgr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ID_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MODE_W-1:0]     act_mode,
    input  logic [ID_W-1:0]       act_id,
    input  logic                  tgt_init,
    input  logic                  tgt_done,
    input  logic                  tgt_cclk_in,
    input  logic [DATA_W-1:0]     tgt_data_in,
    input  logic [DATA_W-1:0]     prom_data,
    input  logic                  up_cclk,
    input  logic [DATA_W-1:0]     up_data_in,
    input  logic [(1<<ID_W)-1:0]  up_cs,
    input  logic                  up_rdwr,
    input  logic [MODE_W-1:0]     up_mode,
    input  logic                  dn_init,
    input  logic                  dn_done,
    output logic [MODE_W-1:0]     tgt_mode,
    output logic                  tgt_mode_oe,
    output logic                  tgt_cs,
    output logic                  tgt_cs_oe,
    output logic                  tgt_rdwr,
    output logic                  tgt_rdwr_oe,
    output logic                  tgt_cclk,
    output logic                  tgt_cclk_oe,
    output logic [DATA_W-1:0]     tgt_data_out,
    output logic                  tgt_data_oe,
    output logic [DATA_W-1:0]     up_data_out,
    output logic                  up_data_oe,
    output logic                  up_init,
    output logic                  up_done,
    output logic                  dn_cclk,
    output logic                  dn_cclk_en,
    output logic [DATA_W-1:0]     dn_data,
    output logic [DATA_W-1:0]     dn_data_en
);
    localparam logic [DATA_W-1:0] MASK_SERIAL = DATA_W'(1);
    localparam logic [DATA_W-1:0] MASK_WIDE   = {DATA_W{1'b1}};

    logic              chip_sel;
    logic              readback;
    logic              from_prom;
    logic [DATA_W-1:0] src_data;
    logic [DATA_W-1:0] fwd_mask;

    always_comb begin
        chip_sel  = !up_cs[act_id];
        from_prom = (act_mode == M_SER_PROM) || (act_mode == M_SMAP_PROM);
        src_data  = from_prom ? prom_data : up_data_in;
        readback  = (act_mode == M_SMAP) && !up_rdwr;
        up_init   = tgt_init && dn_init;
        up_done   = tgt_done && dn_done;
    end

    always_comb begin
        tgt_mode     = '0;
        tgt_mode_oe  = 1'b0;
        tgt_cs       = 1'b0;
        tgt_cs_oe    = 1'b0;
        tgt_rdwr     = 1'b0;
        tgt_rdwr_oe  = 1'b0;
        tgt_cclk     = 1'b0;
        tgt_cclk_oe  = 1'b0;
        tgt_data_out = '0;
        tgt_data_oe  = 1'b0;
        up_data_out  = '0;
        up_data_oe   = 1'b0;
        fwd_mask     = '0;

        if (act_mode != M_EXT) begin
            tgt_mode_oe = 1'b1;
            tgt_cs_oe   = 1'b1;
            tgt_rdwr_oe = 1'b1;
            tgt_cs      = up_cs[act_id];
            tgt_rdwr    = up_rdwr;
        end

        case (cfg_mode_e'(act_mode))
            M_SER_PROM: begin
                tgt_mode     = PINS_SER_MASTER;
                tgt_data_out = src_data;
                tgt_data_oe  = 1'b1;
                fwd_mask     = MASK_SERIAL;
            end
            M_SER_UP: begin
                tgt_mode     = up_mode;
                tgt_data_out = src_data;
                tgt_data_oe  = 1'b1;
                fwd_mask     = MASK_SERIAL;
            end
            M_SMAP_PROM: begin
                tgt_mode     = PINS_SMAP_MASTER;
                tgt_cs       = 1'b0;
                tgt_rdwr     = 1'b1;
                tgt_data_out = src_data;
                tgt_data_oe  = 1'b1;
                fwd_mask     = MASK_WIDE;
            end
            M_SMAP_UP: begin
                tgt_mode     = up_mode;
                tgt_data_out = src_data;
                tgt_data_oe  = 1'b1;
                fwd_mask     = MASK_WIDE;
            end
            M_SLV_SER: begin
                tgt_mode     = up_mode;
                tgt_cclk     = up_cclk;
                tgt_cclk_oe  = 1'b1;
                tgt_data_out = src_data;
                tgt_data_oe  = 1'b1;
            end
            M_JTAG: begin
                tgt_mode = PINS_JTAG;
            end
            M_SMAP: begin
                tgt_mode    = PINS_SMAP_SLAVE;
                tgt_cclk    = up_cclk;
                tgt_cclk_oe = 1'b1;
                if (readback) begin
                    if (chip_sel) begin
                        up_data_out = tgt_data_in;
                        up_data_oe  = 1'b1;
                    end
                end else begin
                    tgt_data_out = src_data;
                    tgt_data_oe  = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    always_comb begin
        dn_cclk_en = |fwd_mask;
        dn_cclk    = dn_cclk_en ? tgt_cclk_in : 1'b0;
        dn_data_en = fwd_mask;
        dn_data    = src_data & fwd_mask;
    end

    assert_no_unsel_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        up_data_oe |-> !up_cs[act_id] && !tgt_data_oe);

    assert_readback_quiet_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == M_SMAP && !up_rdwr) |-> !tgt_data_oe);

    assert_cs_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == M_SMAP_PROM) |-> tgt_cs_oe && !tgt_cs && tgt_rdwr);

    assert_serial_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == M_SER_PROM || act_mode == M_SER_UP) |-> dn_data_en == MASK_SERIAL && dn_cclk_en);

    assert_ext_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == M_EXT) |-> !(tgt_mode_oe || tgt_cs_oe || tgt_rdwr_oe || tgt_cclk_oe
                                  || tgt_data_oe || dn_cclk_en || (|dn_data_en)));

    assert_chain_and_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (up_done |-> tgt_done && dn_done) and (up_init |-> tgt_init && dn_init));
endmodule

// File: rtl/cfg_route_ctrl.sv
module cfg_route_ctrl
    import cfgr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ID_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           mode_sel,
    input  logic [ID_W-1:0]      id_sel,
    input  logic                 prog_req,
    input  logic                 dll_locked,
    input  logic                 tgt_init,
    input  logic                 tgt_done,
    input  logic                 tgt_cclk_in,
    input  logic [DATA_W-1:0]    tgt_data_in,
    input  logic [DATA_W-1:0]    prom_data,
    input  logic                 up_cclk,
    input  logic [DATA_W-1:0]    up_data_in,
    input  logic [(1<<ID_W)-1:0] up_cs,
    input  logic                 up_rdwr,
    input  logic [2:0]           up_mode,
    input  logic                 dn_init,
    input  logic                 dn_done,
    output logic [2:0]           tgt_mode,
    output logic                 tgt_mode_oe,
    output logic                 tgt_cs,
    output logic                 tgt_cs_oe,
    output logic                 tgt_rdwr,
    output logic                 tgt_rdwr_oe,
    output logic                 tgt_cclk,
    output logic                 tgt_cclk_oe,
    output logic [DATA_W-1:0]    tgt_data_out,
    output logic                 tgt_data_oe,
    output logic [DATA_W-1:0]    up_data_out,
    output logic                 up_data_oe,
    output logic                 up_init,
    output logic                 up_done,
    output logic                 dn_cclk,
    output logic                 dn_cclk_en,
    output logic [DATA_W-1:0]    dn_data,
    output logic [DATA_W-1:0]    dn_data_en,
    output logic [DATA_W-1:0]    led,
    output logic                 led_oe
);
    localparam int FLAG_W = 4;
    localparam int SYNC_W = MODE_W + ID_W + FLAG_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {MODE_W'(M_EXT), {ID_W{1'b0}}, {FLAG_W{1'b0}}};

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic [MODE_W-1:0] mode_s, act_mode;
    logic [ID_W-1:0]   id_s, act_id;
    logic              prog_s, done_s, init_s, dll_s;

    assign sync_in = {mode_sel, id_sel, prog_req, tgt_done, tgt_init, dll_locked};

    cfgr_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .dout  (sync_out)
    );

    assign {mode_s, id_s, prog_s, done_s, init_s, dll_s} = sync_out;

    cfgr_mode_ctrl #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_s      (mode_s),
        .id_s        (id_s),
        .prog_s      (prog_s),
        .done_s      (done_s),
        .init_s      (init_s),
        .dll_s       (dll_s),
        .tgt_data_in (tgt_data_in),
        .act_mode    (act_mode),
        .act_id      (act_id),
        .led         (led),
        .led_oe      (led_oe)
    );

    cfgr_route #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W)
    ) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_mode     (act_mode),
        .act_id       (act_id),
        .tgt_init     (tgt_init),
        .tgt_done     (tgt_done),
        .tgt_cclk_in  (tgt_cclk_in),
        .tgt_data_in  (tgt_data_in),
        .prom_data    (prom_data),
        .up_cclk      (up_cclk),
        .up_data_in   (up_data_in),
        .up_cs        (up_cs),
        .up_rdwr      (up_rdwr),
        .up_mode      (up_mode),
        .dn_init      (dn_init),
        .dn_done      (dn_done),
        .tgt_mode     (tgt_mode),
        .tgt_mode_oe  (tgt_mode_oe),
        .tgt_cs       (tgt_cs),
        .tgt_cs_oe    (tgt_cs_oe),
        .tgt_rdwr     (tgt_rdwr),
        .tgt_rdwr_oe  (tgt_rdwr_oe),
        .tgt_cclk     (tgt_cclk),
        .tgt_cclk_oe  (tgt_cclk_oe),
        .tgt_data_out (tgt_data_out),
        .tgt_data_oe  (tgt_data_oe),
        .up_data_out  (up_data_out),
        .up_data_oe   (up_data_oe),
        .up_init      (up_init),
        .up_done      (up_done),
        .dn_cclk      (dn_cclk),
        .dn_cclk_en   (dn_cclk_en),
        .dn_data      (dn_data),
        .dn_data_en   (dn_data_en)
    );

    assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tgt_data_oe && !led_oe && !dn_cclk_en);
endmodule

// File: tb/cfg_route_ctrl_tb.sv
module cfg_route_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode_sel;
    logic [1:0] id_sel;
    logic       prog_req, dll_locked, tgt_init, tgt_done, tgt_cclk_in;
    logic [7:0] tgt_data_in, prom_data, up_data_in;
    logic       up_cclk, up_rdwr, dn_init, dn_done;
    logic [3:0] up_cs;
    logic [2:0] up_mode;
    logic [2:0] tgt_mode;
    logic       tgt_mode_oe, tgt_cs, tgt_cs_oe, tgt_rdwr, tgt_rdwr_oe, tgt_cclk, tgt_cclk_oe;
    logic [7:0] tgt_data_out, up_data_out, dn_data, dn_data_en, led;
    logic       tgt_data_oe, up_data_oe, up_init, up_done, dn_cclk, dn_cclk_en, led_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_route_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .id_sel(id_sel),
        .prog_req(prog_req), .dll_locked(dll_locked), .tgt_init(tgt_init),
        .tgt_done(tgt_done), .tgt_cclk_in(tgt_cclk_in), .tgt_data_in(tgt_data_in),
        .prom_data(prom_data), .up_cclk(up_cclk), .up_data_in(up_data_in),
        .up_cs(up_cs), .up_rdwr(up_rdwr), .up_mode(up_mode), .dn_init(dn_init),
        .dn_done(dn_done), .tgt_mode(tgt_mode), .tgt_mode_oe(tgt_mode_oe),
        .tgt_cs(tgt_cs), .tgt_cs_oe(tgt_cs_oe), .tgt_rdwr(tgt_rdwr),
        .tgt_rdwr_oe(tgt_rdwr_oe), .tgt_cclk(tgt_cclk), .tgt_cclk_oe(tgt_cclk_oe),
        .tgt_data_out(tgt_data_out), .tgt_data_oe(tgt_data_oe),
        .up_data_out(up_data_out), .up_data_oe(up_data_oe), .up_init(up_init),
        .up_done(up_done), .dn_cclk(dn_cclk), .dn_cclk_en(dn_cclk_en),
        .dn_data(dn_data), .dn_data_en(dn_data_en), .led(led), .led_oe(led_oe)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit rand_on  = 1'b1;

    // reference model state: a two-entry history of the selector inputs
    int  hist_mode [2];
    int  hist_id   [2];
    bit  hist_prog [2];
    bit  hist_done [2];
    bit  hist_init [2];
    bit  hist_dll  [2];
    int  ref_mode, ref_id;
    logic [7:0] ref_led;
    bit  ref_led_oe;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h (mode %0d)", req, what, act, exp, ref_mode);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                hist_mode[k] = 7; hist_id[k] = 0; hist_prog[k] = 0;
                hist_done[k] = 0; hist_init[k] = 0; hist_dll[k] = 0;
            end
            ref_mode = 7; ref_id = 0; ref_led = 8'h00; ref_led_oe = 1'b0;
        end else begin
            if (hist_done[1] && !hist_prog[1]) begin
                ref_led = tgt_data_in; ref_led_oe = 1'b1;
            end else if (hist_init[1] && !hist_prog[1]) begin
                ref_led = 8'h00; ref_led_oe = 1'b0;
            end else begin
                ref_led = 8'h00;
                if (ref_mode < 7) ref_led[ref_mode] = 1'b1;
                ref_led[7] = hist_dll[1];
                ref_led_oe = 1'b1;
            end
            if (hist_prog[1] || !hist_done[1]) begin
                ref_mode = hist_mode[1];
                ref_id   = hist_id[1];
            end
            hist_mode[1] = hist_mode[0]; hist_id[1] = hist_id[0];
            hist_prog[1] = hist_prog[0]; hist_done[1] = hist_done[0];
            hist_init[1] = hist_init[0]; hist_dll[1] = hist_dll[0];
            hist_mode[0] = mode_sel; hist_id[0] = id_sel; hist_prog[0] = prog_req;
            hist_done[0] = tgt_done; hist_init[0] = tgt_init; hist_dll[0] = dll_locked;
        end
    endtask

    task automatic compare_all();
        logic [2:0] e_mode;
        logic       e_on, e_cs, e_rdwr, e_cclk_oe, e_cclk, e_tdoe, e_udoe;
        logic       sel, rb;
        logic [7:0] src, e_tdata, e_udata, e_mask;
        e_on = (ref_mode != 7);
        case (ref_mode)
            0: e_mode = 3'b000;
            2: e_mode = 3'b011;
            5: e_mode = 3'b101;
            6: e_mode = 3'b110;
            7: e_mode = 3'b000;
            default: e_mode = up_mode;
        endcase
        e_cs   = (ref_mode == 2 || !e_on) ? 1'b0 : up_cs[ref_id];
        e_rdwr = (ref_mode == 2) ? 1'b1 : (e_on ? up_rdwr : 1'b0);
        e_cclk_oe = (ref_mode == 4 || ref_mode == 6);
        e_cclk    = e_cclk_oe ? up_cclk : 1'b0;
        src = (ref_mode == 0 || ref_mode == 2) ? prom_data : up_data_in;
        rb  = (ref_mode == 6) && !up_rdwr;
        sel = !up_cs[ref_id];
        e_tdoe = (ref_mode <= 4) || (ref_mode == 6 && !rb);
        e_tdata = e_tdoe ? src : 8'h00;
        e_udoe  = rb && sel;
        e_udata = e_udoe ? tgt_data_in : 8'h00;
        e_mask  = (ref_mode <= 1) ? 8'h01 : ((ref_mode <= 3) ? 8'hFF : 8'h00);

        if (!rst_n) begin
            chk("R2", "reset enables", {tgt_mode_oe, tgt_cs_oe, tgt_rdwr_oe, tgt_cclk_oe,
                tgt_data_oe, up_data_oe, dn_cclk_en, led_oe}, 0);
            chk("R2", "reset fwd", dn_data_en, 0);
            return;
        end
        chk("R3", "mode pins", {tgt_mode_oe, tgt_mode}, {e_on, e_mode});
        chk("R4", "cs/rdwr", {tgt_cs_oe, tgt_cs, tgt_rdwr_oe, tgt_rdwr}, {e_on, e_cs, e_on, e_rdwr});
        chk("R5", "target data", {tgt_data_oe, tgt_data_out}, {e_tdoe, e_tdata});
        chk("R6", "target cclk", {tgt_cclk_oe, tgt_cclk}, {e_cclk_oe, e_cclk});
        if (ref_mode <= 1)
            chk("R7", "serial forward", {dn_cclk_en, dn_cclk, dn_data_en, dn_data},
                {1'b1, tgt_cclk_in, e_mask, src & e_mask});
        else
            chk("R8", "wide/no forward", {dn_cclk_en, dn_cclk, dn_data_en, dn_data},
                {e_mask != 0, (e_mask != 0) & tgt_cclk_in, e_mask, src & e_mask});
        chk("R9", "readback", {up_data_oe, up_data_out}, {e_udoe, e_udata});
        chk("R10", "no unselected drive", up_data_oe & (up_cs[ref_id] | tgt_data_oe), 0);
        chk("R11", "chain flags", {up_init, up_done}, {tgt_init & dn_init, tgt_done & dn_done});
        if (ref_mode == 7)
            chk("R12", "external quiet", {tgt_mode_oe, tgt_cs_oe, tgt_rdwr_oe, tgt_cclk_oe,
                tgt_data_oe, dn_cclk_en, dn_data_en}, 0);
        if (ref_led_oe && !(hist_done[1] && !hist_prog[1]))
            chk("R13", "led setup", {led_oe, led}, {ref_led_oe, ref_led});
        else
            chk("R14", "led cfg/done", {led_oe, led}, {ref_led_oe, ref_led});
    endtask

    task automatic tick();
        if (rand_on) begin
            prom_data   = 8'($urandom);
            up_data_in  = 8'($urandom);
            tgt_data_in = 8'($urandom);
            up_cs       = 4'($urandom);
            up_cclk     = 1'($urandom);
            tgt_cclk_in = 1'($urandom);
            up_mode     = 3'($urandom);
            dn_init     = 1'($urandom);
            dn_done     = 1'($urandom);
            dll_locked  = 1'($urandom);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; mode_sel = 3'd0; id_sel = 2'd0; prog_req = 1'b0;
        tgt_init = 1'b0; tgt_done = 1'b0; up_rdwr = 1'b1;
        repeat (3) tick();                       // R2 reset state
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R2", "mode 7 right after reset", tgt_mode_oe, 1'b0);

        // sweep all eight modes with changing data and chip selects (R3..R13)
        for (int m = 0; m < 8; m++) begin
            mode_sel = 3'(m);
            id_sel   = 2'(m);
            for (int c = 0; c < 12; c++) begin
                up_rdwr = c[0];
                tick();
            end
        end

        // readback in mode 6 for every ID (R9, R10)
        mode_sel = 3'd6;
        up_rdwr  = 1'b0;
        for (int i = 0; i < 4; i++) begin
            id_sel = 2'(i);
            for (int c = 0; c < 10; c++) tick();
        end
        // targeted readback: selected, then deselected
        rand_on = 1'b0;
        up_cs = 4'hF; up_cs[3] = 1'b0; tgt_data_in = 8'hA5;
        tick();
        chk("R9", "selected readback drive", {up_data_oe, up_data_out}, {1'b1, 8'hA5});
        up_cs = 4'hF;
        tick();
        chk("R10", "deselected readback no drive", up_data_oe, 1'b0);
        rand_on = 1'b1;

        // mode 3 and then configuring: LEDs dark (R14)
        up_rdwr = 1'b1; mode_sel = 3'd3; id_sel = 2'd1;
        repeat (4) tick();
        tgt_init = 1'b1;
        repeat (4) tick();
        chk("R14", "led dark while configuring", led_oe, 1'b0);

        // done: selector changes are ignored (R1), LEDs mirror target data (R14)
        tgt_done = 1'b1;
        repeat (4) tick();
        mode_sel = 3'd5;
        repeat (6) tick();
        chk("R1", "mode held after done", dn_data_en, 8'hFF);
        chk("R14", "led follows data", led_oe, 1'b1);

        // program request re-opens the selector (R1)
        prog_req = 1'b1;
        repeat (4) tick();
        chk("R1", "mode applied under program request", {tgt_mode_oe, tgt_mode}, {1'b1, 3'b101});
        prog_req = 1'b0; tgt_done = 1'b0; tgt_init = 1'b0;
        mode_sel = 3'd2;
        repeat (4) tick();
        chk("R4", "mode 2 forced cs", {tgt_cs_oe, tgt_cs, tgt_rdwr}, {1'b1, 1'b0, 1'b1});
        chk("R13", "led one-hot mode 2", led[6:0], 7'b0000100);
        mode_sel = 3'd7;
        repeat (4) tick();
        chk("R12", "external target pins quiet", tgt_data_oe, 1'b0);
        chk("R13", "led mode 7 low bits clear", led[6:0], 7'b0);

        // reset in the middle of operation (R2)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) tick();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) tick();

        finish_run();
    end
endmodule